// File: doc/BRIEF.md
# Register-Mapped Serial Port with Maskable Interrupt

This block is a byte-oriented asynchronous serial port that a processor controls through six word registers. Software sets the bit rate through a divisor register and pushes bytes into a transmit queue. The transmitter sends each byte as a frame of one start bit, eight data bits with the least significant bit first, and one stop bit. The receiver oversamples the incoming line at sixteen times the bit rate and queues every good byte for software to read.

Five events latch into a status register: a byte received, a byte sent, a framing error, the receive queue filling up, and the transmit queue draining. An interrupt line reports any latched event whose mask bit is clear. Software acknowledges events by writing the status register. A bit written as zero is cleared, so writing zero clears every event.

The bus has no back-pressure. A request completes in the cycle it is issued, and read data appears one cycle later. Flow control is left to software. Before pushing a byte, software polls the transmit-space flag. A push into a full queue is dropped, and a read from an empty receive queue repeats the last byte it returned.

Top module: `uart_mmio`

## Requirements
- R1: Registers sit at word addresses 0 line control (8 bits, read back), 1 mask (6 bits, resets to 0x3F), 2 divisor (16 bits, resets to 1), 3 status, 4 receive data, 5 transmit data. Reads return data in the cycle after the request. After reset, status reads 0x20.
- R2: One oversampling tick occurs every divisor clock cycles, and every serial bit lasts 16 ticks. With a divisor of 3, each bit therefore lasts 48 clocks.
- R3: The transmit line idles high. Each byte goes out as a start bit (low), eight data bits least significant first, and a stop bit (high).
- R4: The receiver arms on a falling edge and confirms the start bit at its 8th tick. A low pulse shorter than half a bit receives nothing.
- R5: Receive data reads return bytes oldest first. A read while the receive queue is empty returns the last byte previously read.
- R6: The transmit queue holds 16 bytes and drops a write made while it is full. Status bit 5 reads 1 exactly when the queue has space.
- R7: Status latches events at these bits: bit 0 byte received, bit 1 byte sent, bit 2 framing error, bit 3 receive queue became full, bit 4 transmit queue became empty.
- R8: A write to status clears each of bits 0 to 4 that is written as 0 and leaves the others as they are.
- R9: `irq` is high exactly when some status bit 0 to 4 is set while its mask bit (same position) is 0. A mask bit of 1 disables that source.
- R10: A frame whose stop-bit sample is low sets bit 2 and is neither stored nor counted as received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| irq | output | 1 | Interrupt request |

## Verification
A wrong shifter or sampling phase shows up as a corrupted byte in the receive queue after one frame, about 160 divisor periods. It also shows on `txd` as a bit of the wrong length, which the bench decodes directly from the line. A wrong queue pointer shows up within one 16-byte burst as a misordered, lost or extra byte. A wrong status or mask state shows on `irq` in the cycle after the register write that exposes it.

// File: rtl/uart_pkg.sv
package uart_pkg;
  typedef enum logic [2:0] {
    A_LCTL  = 3'd0,
    A_MASK  = 3'd1,
    A_DIV   = 3'd2,
    A_STAT  = 3'd3,
    A_RXDAT = 3'd4,
    A_TXDAT = 3'd5
  } reg_addr_e;

  localparam int S_RXDONE  = 0;
  localparam int S_TXDONE  = 1;
  localparam int S_FERR    = 2;
  localparam int S_RXFULL  = 3;
  localparam int S_TXEMPTY = 4;
  localparam int N_SRC     = 5;
  localparam int TICKS_PER_BIT = 16;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  logic [W-1:0] mem [DEPTH];
  logic [AW:0] wp, rp, cnt;

  assign cnt   = wp - rp;
  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign dout  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) begin
        mem[wp[AW-1:0]] <= din;
        wp <= wp + 1'b1;
      end
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));
  a_r6_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> $stable(wp));
endmodule

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt, lim;

  assign lim  = (div == '0) ? '0 : div - 1'b1;
  assign tick = (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= tick ? '0 : cnt + 1'b1;
  end

  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div > 1 && $stable(div)) |=> !tick);
endmodule

// File: rtl/uart_tx.sv
module uart_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       have,
  input  logic [7:0] data,
  output logic       pop,
  output logic       done,
  output logic       txd
);
  import uart_pkg::*;
  logic       busy;
  logic [9:0] sh;
  logic [3:0] sub, bitn;
  logic       last_tick;

  assign last_tick = tick && (sub == 4'(TICKS_PER_BIT - 1));
  assign pop  = !busy && tick && have;
  assign done = busy && last_tick && (bitn == 4'd9);
  assign txd  = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      sub  <= '0;
      bitn <= '0;
    end else if (pop) begin
      sh   <= {1'b1, data, 1'b0};
      busy <= 1'b1;
      sub  <= '0;
      bitn <= '0;
    end else if (busy && tick) begin
      sub <= sub + 1'b1;
      if (last_tick) begin
        if (bitn == 4'd9) busy <= 1'b0;
        else begin
          bitn <= bitn + 1'b1;
          sh   <= {1'b1, sh[9:1]};
        end
      end
    end
  end

  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  a_r3_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bitn == 4'd9) |-> txd);
endmodule

// File: rtl/uart_rx.sv
module uart_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  output logic       push,
  output logic       ferr,
  output logic [7:0] byte_out
);
  import uart_pkg::*;
  typedef enum logic [1:0] {IDLE, START, DATA, STOP} rx_st_e;
  rx_st_e     st;
  logic       s1, s2, s3;
  logic [3:0] sub;
  logic [2:0] bitn;
  logic       mid, last_tick;

  assign mid       = tick && (sub == 4'(TICKS_PER_BIT/2 - 1));
  assign last_tick = tick && (sub == 4'(TICKS_PER_BIT - 1));
  assign push = (st == STOP) && last_tick && s2;
  assign ferr = (st == STOP) && last_tick && !s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
      st <= IDLE;
      sub <= '0;
      bitn <= '0;
      byte_out <= '0;
    end else begin
      s1 <= rxd; s2 <= s1; s3 <= s2;
      case (st)
        IDLE: if (s3 && !s2) begin st <= START; sub <= '0; end
        START: if (mid) begin
                 sub <= '0;
                 st  <= s2 ? IDLE : DATA;
                 bitn <= '0;
               end else if (tick) sub <= sub + 1'b1;
        DATA: if (tick) begin
                sub <= sub + 1'b1;
                if (last_tick) begin
                  byte_out <= {s2, byte_out[7:1]};
                  bitn <= bitn + 1'b1;
                  if (bitn == 3'd7) st <= STOP;
                end
              end
        STOP: if (tick) begin
                sub <= sub + 1'b1;
                if (last_tick) st <= IDLE;
              end
        default: st <= IDLE;
      endcase
    end
  end

  a_r4_start_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
    (st == START && mid && s2) |=> st == IDLE);
endmodule

// File: rtl/uart_mmio.sv
module uart_mmio #(
  parameter int DIV_W = 16,
  parameter int DEPTH = 16,
  parameter logic [15:0] DIV_RESET = 16'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        txd,
  input  logic        rxd,
  output logic        irq
);
  import uart_pkg::*;
  logic [7:0]       lctl;
  logic [5:0]       mask;
  logic [DIV_W-1:0] div;
  logic [N_SRC-1:0] stat, set_ev;
  logic [7:0]       last_rx, tx_dout, rx_dout, rx_byte;
  logic tick, tx_pop, tx_done, tx_empty, tx_full, tx_push;
  logic rx_push, rx_ferr, rx_pop, rx_empty, rx_full;
  logic rx_full_q, tx_empty_q, wr, rd;

  assign wr = bus_sel && bus_we;
  assign rd = bus_sel && !bus_we;
  assign tx_push = wr && (bus_addr == A_TXDAT);
  assign rx_pop  = rd && (bus_addr == A_RXDAT);

  uart_baud #(.DIV_W(DIV_W)) u_baud (.clk, .rst_n, .div, .tick);

  uart_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk, .rst_n, .push(tx_push), .din(bus_wdata[7:0]), .pop(tx_pop),
    .dout(tx_dout), .empty(tx_empty), .full(tx_full));

  uart_tx u_tx (.clk, .rst_n, .tick, .have(!tx_empty), .data(tx_dout),
    .pop(tx_pop), .done(tx_done), .txd);

  uart_rx u_rx (.clk, .rst_n, .tick, .rxd, .push(rx_push), .ferr(rx_ferr),
    .byte_out(rx_byte));

  uart_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk, .rst_n, .push(rx_push), .din(rx_byte), .pop(rx_pop),
    .dout(rx_dout), .empty(rx_empty), .full(rx_full));

  always_comb begin
    set_ev = '0;
    set_ev[S_RXDONE]  = rx_push;
    set_ev[S_TXDONE]  = tx_done;
    set_ev[S_FERR]    = rx_ferr;
    set_ev[S_RXFULL]  = rx_full && !rx_full_q;
    set_ev[S_TXEMPTY] = tx_empty && !tx_empty_q;
  end

  assign irq = |(stat & ~mask[N_SRC-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lctl <= '0;
      mask <= '1;
      div  <= DIV_W'(DIV_RESET);
      stat <= '0;
      last_rx <= '0;
      bus_rdata <= '0;
      rx_full_q <= 1'b0;
      tx_empty_q <= 1'b1;
    end else begin
      rx_full_q  <= rx_full;
      tx_empty_q <= tx_empty;
      if (wr && bus_addr == A_STAT) stat <= (stat & bus_wdata[N_SRC-1:0]) | set_ev;
      else                          stat <= stat | set_ev;
      if (wr) begin
        case (bus_addr)
          A_LCTL: lctl <= bus_wdata[7:0];
          A_MASK: mask <= bus_wdata[5:0];
          A_DIV:  div  <= bus_wdata[DIV_W-1:0];
          default: ;
        endcase
      end
      if (rd) begin
        case (bus_addr)
          A_LCTL: bus_rdata <= {8'd0, lctl};
          A_MASK: bus_rdata <= {10'd0, mask};
          A_DIV:  bus_rdata <= 16'(div);
          A_STAT: bus_rdata <= {10'd0, !tx_full, stat};
          A_RXDAT: begin
            bus_rdata <= {8'd0, rx_empty ? last_rx : rx_dout};
            if (!rx_empty) last_rx <= rx_dout;
          end
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  a_r7_rx_done_latched: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> stat[S_RXDONE]);
  a_r10_error_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ferr |-> !rx_push);
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[N_SRC-1:0] == '1) |-> !irq);
endmodule

// File: tb/uart_mmio_test.sv
module uart_mmio_test;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic txd, irq, loop = 1, drv = 1;
  wire rxd_w = loop ? txd : drv;
  int checks = 0, errors = 0;
  logic [15:0] rv;
  logic ok;

  uart_mmio uut (.clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata,
    .bus_rdata, .txd, .rxd(rxd_w), .irq);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic wait_bit(input int b, input int lim, output logic hit);
    logic [15:0] s;
    hit = 0;
    for (int i = 0; i < lim && !hit; i++) begin
      rd(3, s);
      hit = s[b];
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] dec;
    idle(3); rst_n = 1; idle(2);
    // R1 reset state and readback
    chk("R3 txd idle", {15'd0, txd}, 16'd1);
    chk("R9 irq reset", {15'd0, irq}, 16'd0);
    rd(1, rv); chk("R1 mask reset", rv, 16'h003F);
    rd(2, rv); chk("R1 divisor reset", rv, 16'd1);
    rd(3, rv); chk("R1 status reset", rv, 16'h0020);
    wr(0, 16'h0020); rd(0, rv); chk("R1 line ctl readback", rv, 16'h0020);
    wr(2, 16'd3); rd(2, rv); chk("R1 divisor readback", rv, 16'd3);

    // R2/R3 bit timing and order, divisor 3 -> 48 clocks per bit
    wr(5, 16'h0055);
    while (txd) @(negedge clk);
    n = 0; while (!txd) begin n++; @(negedge clk); end
    chk("R2 start bit length", 16'(n), 16'd48);
    n = 0; while (txd) begin n++; @(negedge clk); end
    chk("R2 data bit length", 16'(n), 16'd48);
    wait_bit(0, 400, ok); rd(4, rv); chk("R3 loop 0x55", rv, 16'h0055);
    wr(3, 0);
    wr(5, 16'h00A3);
    while (txd) @(negedge clk);
    idle(24);
    dec = 0;
    for (int k = 0; k < 8; k++) begin idle(48); dec[k] = txd; end
    chk("R3 lsb-first on line", {8'd0, dec}, 16'h00A3);
    idle(48); chk("R3 stop bit high", {15'd0, txd}, 16'd1);
    wait_bit(0, 400, ok); rd(4, rv); chk("R4 loop 0xA3", rv, 16'h00A3);
    wr(3, 0);

    // R4/R5 sweep every byte value, divisor 2
    wr(2, 16'd2);
    n = 0;
    for (int v = 0; v < 256; v++) begin
      wr(5, 16'(v));
      wait_bit(0, 400, ok);
      rd(4, rv);
      if (rv !== 16'(v) || !ok) begin
        n++;
        $display("FAIL R4 sweep byte: actual=%h expected=%h", rv, 16'(v));
      end
      wr(3, 0);
    end
    checks++; if (n != 0) errors++;

    // R7/R8/R9 status and mask, using one loop byte
    wr(5, 16'h0011);
    wait_bit(0, 400, ok); idle(40);
    rd(3, rv); chk("R7 rx/tx done, tx empty", rv, 16'h0033);
    chk("R9 all masked", {15'd0, irq}, 16'd0);
    wr(1, 16'h003E); chk("R9 rx source enabled", {15'd0, irq}, 16'd1);
    wr(3, 16'h001E); rd(3, rv); chk("R8 clear bit0 only", rv, 16'h0032);
    chk("R9 cleared source quiet", {15'd0, irq}, 16'd0);
    wr(1, 16'h003D); chk("R9 tx done source", {15'd0, irq}, 16'd1);
    wr(3, 0); chk("R8 write zero clears all", {15'd0, irq}, 16'd0);
    rd(4, rv); chk("R5 empty read repeats last", rv, 16'h0011);
    wr(1, 16'h003F);

    // R5/R7 burst of 16 fills receive queue
    for (int i = 0; i < 16; i++) wr(5, 16'(8'h30 + i));
    wait_bit(3, 6000, ok); chk("R7 rx full latched", {15'd0, ok}, 16'd1);
    for (int i = 0; i < 16; i++) begin
      rd(4, rv); chk("R5 oldest first", rv, 16'(8'h30 + i));
    end
    rd(4, rv); chk("R5 empty repeats last", rv, 16'h003F);
    wr(3, 0);

    // R6 overflow: 18 writes, 17 travel
    for (int i = 0; i < 18; i++) wr(5, 16'(8'h80 + i));
    rd(3, rv); chk("R6 no space when full", {15'd0, rv[5]}, 16'd0);
    n = 0;
    for (int i = 0; i < 17; i++) begin
      wait_bit(0, 400, ok);
      rd(4, rv);
      wr(3, 0);
      if (rv !== 16'(8'h80 + i)) n++;
    end
    chk("R6 17 bytes in order", 16'(n), 16'd0);
    idle(800);
    rd(3, rv); chk("R6 dropped write not sent", {15'd0, rv[0]}, 16'd0);
    chk("R6 space again", {15'd0, rv[5]}, 16'd1);
    wr(3, 0);

    // R4 glitch rejection, R10 framing error (bit = 32 clocks)
    loop = 0;
    idle(5); drv = 0; idle(6); drv = 1; idle(400);
    rd(3, rv); chk("R4 glitch ignored", rv & 16'h001F, 16'd0);
    dec = 8'h5A;
    drv = 0; idle(32);
    for (int k = 0; k < 8; k++) begin drv = dec[k]; idle(32); end
    drv = 0; idle(32); drv = 1; idle(40);
    rd(3, rv); chk("R10 framing error only", rv & 16'h0007, 16'h0004);
    rd(4, rv); chk("R10 bad frame not stored", rv, 16'h0090);
    wr(1, 16'h003B); chk("R9 error source irq", {15'd0, irq}, 16'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule